// File: doc/BRIEF.md
# Short-Address Bus Slave Window Decoder with Interrupt Acknowledge

This block is the bus-slave front end of a module that exposes a 64-byte register window in a 16-bit address space. On each bus cycle request it checks the address-modifier code and the upper ten address bits against its strap settings. On a match it emits a single-cycle register strobe carrying the 16-bit word offset (address bits 5..1) and the transfer direction. A cycle acknowledge follows one clock later. The data registers themselves live outside the block, except for two that belong to the interrupter: the request level and the status/ID vector.

Two strap-selected placement modes exist. In logical-address mode the two top address bits must both be 1 and the 8-bit switch value must match address bits 13..6. In that mode an interrupt acknowledge returns the switch value as its status/ID byte. In free-placement mode two further strap bits give address bits 15..14, so the window can sit in any 64-byte block. In that mode the status/ID byte is the host-written vector. The interrupter drives one of seven request lines, chosen by a 3-bit level. It answers an acknowledge cycle only for its own level while a request is pending, and it drops the request when that acknowledge completes.

Top module: `a16_window_slave`

## Requirements
- R1: Only address-modifier codes 0x29 and 0x2D are accepted. A data cycle with any other code produces neither a register strobe nor an acknowledge.
- R2: With `strap_fixed`=1, a data cycle hits exactly when address bits 15..14 are 2'b11 and bits 13..6 equal `strap_la`.
- R3: With `strap_fixed`=0, a data cycle hits exactly when address bits 15..14 equal `strap_hi` and bits 13..6 equal `strap_la`.
- R4: For a cycle request sampled at edge N that hits, `reg_stb` is high for the cycle after edge N, with `reg_off` equal to address bits 5..1 and `reg_wr` equal to the request direction. `cyc_ack` is high for the cycle after edge N+1.
- R5: A hitting write to word offset 0x16 loads the vector from `cyc_wdata[7:0]`, and a hitting write to word offset 0x17 loads the level from `cyc_wdata[2:0]`. Both reset to 0.
- R6: Request line `irq_req[k]` (k = 1..7) is high only while a request is pending and the level equals k. Level 0 drives no line.
- R7: A pulse on `irq_raise` makes the request pending. The request stays pending until an accepted acknowledge; a rejected acknowledge leaves it pending.
- R8: An acknowledge cycle (`cyc_iack`=1) is accepted only when `iack_lvl` equals a non-zero level and a request is pending. Otherwise it gets no acknowledge.
- R9: An accepted acknowledge raises `cyc_ack` two edges after the request, with `status_id` equal to `strap_la` when `strap_fixed`=1, or to the vector when `strap_fixed`=0.
- R10: The pending request is cleared at the edge that raises the acknowledge, so the request line is low in the same cycle as `cyc_ack`. An `irq_raise` at that same edge wins and keeps it pending.
- R11: After reset, `reg_stb`, `cyc_ack`, `status_id` and all request lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fixed | input | 1 | 1: logical-address placement, 0: free placement |
| strap_hi | input | 2 | Address bits 15..14 used in free placement |
| strap_la | input | 8 | Switch value compared with address bits 13..6 |
| cyc_req | input | 1 | One-cycle bus cycle request |
| cyc_iack | input | 1 | Request is an interrupt acknowledge |
| cyc_addr | input | 16 | Cycle address |
| cyc_am | input | 6 | Address-modifier code |
| cyc_wr | input | 1 | 1: write, 0: read |
| cyc_wdata | input | 16 | Write data |
| iack_lvl | input | 3 | Level being acknowledged |
| irq_raise | input | 1 | Pulse that makes an interrupt request pending |
| reg_stb | output | 1 | One-cycle register strobe |
| reg_off | output | 5 | Word offset inside the window |
| reg_wr | output | 1 | Direction of the strobed access |
| cyc_ack | output | 1 | Cycle acknowledge |
| status_id | output | 8 | Status/ID byte returned with an interrupt acknowledge |
| irq_req | output | 7 | Request lines 7..1, active high |

## Verification
Directed cycles put addresses just inside and just outside the window in both placement modes. They flip one top bit, use the switch value, and use a legal versus an illegal modifier code, which separates the fixed-prefix rule from the strap-bit rule and the modifier filter. Acknowledge cycles are sent at the wrong level, with nothing pending, at level 0 and at the right level. These cases show that acceptance depends on all three conditions and that the returned byte follows the placement mode. A seeded random stream then mixes near-hits and misses with random offsets and directions and compares the strobe, the offset and the acknowledge timing against a bench model of the decode rule.

// File: rtl/a16s_pkg.sv
package a16s_pkg;
  localparam int unsigned ADDR_W_D = 16;
  localparam int unsigned WIN_LSB_D = 6;
  localparam int unsigned AM_W_D = 6;
  localparam int unsigned DATA_W_D = 16;
  localparam int unsigned ID_W_D = 8;
  localparam int unsigned LVL_W_D = 3;
  localparam int unsigned NAM_D = 2;
  localparam logic [NAM_D*AM_W_D-1:0] AM_LIST_D = {6'h2D, 6'h29};

  typedef enum logic {
    PLACE_FREE  = 1'b0,
    PLACE_FIXED = 1'b1
  } place_e;
endpackage

// File: rtl/win_match.sv
module win_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_LSB = 6,
  parameter int unsigned AM_W = 6,
  parameter int unsigned NAM = 2,
  parameter logic [NAM*AM_W-1:0] AM_LIST = {6'h2D, 6'h29},
  localparam int unsigned SW_W = ADDR_W - WIN_LSB - 2
) (
  input  logic              place_fixed,
  input  logic [1:0]        strap_hi,
  input  logic [SW_W-1:0]   strap_la,
  input  logic [ADDR_W-1:0] addr,
  input  logic [AM_W-1:0]   am,
  output logic              am_ok,
  output logic              hit
);
  logic [NAM-1:0] am_eq;
  logic [1:0]     top_want;
  logic           top_ok;
  logic           sw_ok;

  for (genvar g = 0; g < NAM; g++) begin : g_am
    assign am_eq[g] = (am == AM_LIST[g*AM_W +: AM_W]);
  end

  always_comb begin
    am_ok    = |am_eq;
    top_want = (place_fixed == a16s_pkg::PLACE_FIXED) ? 2'b11 : strap_hi;
    top_ok   = (addr[ADDR_W-1 -: 2] == top_want);
    sw_ok    = (addr[ADDR_W-3 -: SW_W] == strap_la);
    hit      = am_ok && top_ok && sw_ok;
  end
endmodule

// File: rtl/irq_level_unit.sv
module irq_level_unit #(
  parameter int unsigned LVL_W = 3,
  parameter int unsigned ID_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NLINES = (1 << LVL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vec,
  input  logic              wr_lvl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              raise,
  input  logic              iack_take,
  output logic [LVL_W-1:0]  level,
  output logic [ID_W-1:0]   vector,
  output logic              pending,
  output logic [NLINES:1]   irq_req
);
  logic [LVL_W-1:0] level_q, level_d;
  logic [ID_W-1:0]  vector_q, vector_d;
  logic             pend_q, pend_d;

  always_comb begin
    level_d  = level_q;
    vector_d = vector_q;
    pend_d   = pend_q;
    if (wr_lvl) level_d = wdata[LVL_W-1:0];
    if (wr_vec) vector_d = wdata[ID_W-1:0];
    if (iack_take) pend_d = 1'b0;
    if (raise) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      vector_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      level_q  <= level_d;
      vector_q <= vector_d;
      pend_q   <= pend_d;
    end
  end

  for (genvar k = 1; k <= NLINES; k++) begin : g_line
    assign irq_req[k] = pend_q && (level_q == LVL_W'(k));
  end

  assign level   = level_q;
  assign vector  = vector_q;
  assign pending = pend_q;

  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !iack_take) |=> pend_q);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_take && !raise) |=> (irq_req == '0));

  p_lines_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_req));
endmodule

// File: rtl/a16_window_slave.sv
module a16_window_slave #(
  parameter int unsigned ADDR_W = a16s_pkg::ADDR_W_D,
  parameter int unsigned WIN_LSB = a16s_pkg::WIN_LSB_D,
  parameter int unsigned AM_W = a16s_pkg::AM_W_D,
  parameter int unsigned DATA_W = a16s_pkg::DATA_W_D,
  parameter int unsigned ID_W = a16s_pkg::ID_W_D,
  parameter int unsigned LVL_W = a16s_pkg::LVL_W_D,
  parameter int unsigned VEC_WOFF = 22,
  parameter int unsigned LVL_WOFF = 23,
  localparam int unsigned SW_W = ADDR_W - WIN_LSB - 2,
  localparam int unsigned OFF_W = WIN_LSB - 1,
  localparam int unsigned NLINES = (1 << LVL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_fixed,
  input  logic [1:0]        strap_hi,
  input  logic [SW_W-1:0]   strap_la,
  input  logic              cyc_req,
  input  logic              cyc_iack,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [AM_W-1:0]   cyc_am,
  input  logic              cyc_wr,
  input  logic [DATA_W-1:0] cyc_wdata,
  input  logic [LVL_W-1:0]  iack_lvl,
  input  logic              irq_raise,
  output logic              reg_stb,
  output logic [OFF_W-1:0]  reg_off,
  output logic              reg_wr,
  output logic              cyc_ack,
  output logic [ID_W-1:0]   status_id,
  output logic [NLINES:1]   irq_req
);
  logic              am_ok, dec_hit;
  logic [LVL_W-1:0]  level;
  logic [ID_W-1:0]   vector;
  logic              pending;
  logic              iack_ok;

  // stage 1: strobe
  logic              stb_q, stb_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic              iak_q, iak_d;
  // stage 2: acknowledge
  logic              ack_q, ack_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic              wr_vec, wr_lvl;
  logic              unused_bit;

  assign unused_bit = cyc_addr[0];

  win_match #(
    .ADDR_W (ADDR_W),
    .WIN_LSB(WIN_LSB),
    .AM_W   (AM_W),
    .NAM    (a16s_pkg::NAM_D),
    .AM_LIST(a16s_pkg::AM_LIST_D)
  ) i_match (
    .place_fixed(strap_fixed),
    .strap_hi   (strap_hi),
    .strap_la   (strap_la),
    .addr       (cyc_addr),
    .am         (cyc_am),
    .am_ok      (am_ok),
    .hit        (dec_hit)
  );

  assign iack_ok = cyc_req && cyc_iack && pending &&
                   (level != '0) && (iack_lvl == level);

  always_comb begin
    stb_d = cyc_req && !cyc_iack && dec_hit;
    off_d = off_q;
    wr_d  = wr_q;
    wd_d  = wd_q;
    if (stb_d) begin
      off_d = cyc_addr[WIN_LSB-1:1];
      wr_d  = cyc_wr;
      wd_d  = cyc_wdata;
    end
    iak_d  = iack_ok;
    wr_vec = stb_q && wr_q && (off_q == OFF_W'(VEC_WOFF));
    wr_lvl = stb_q && wr_q && (off_q == OFF_W'(LVL_WOFF));
    ack_d  = stb_q || iak_q;
    id_d   = '0;
    if (iak_q) id_d = (strap_fixed == a16s_pkg::PLACE_FIXED) ? strap_la : vector;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      off_q <= '0;
      wr_q  <= 1'b0;
      wd_q  <= '0;
      iak_q <= 1'b0;
      ack_q <= 1'b0;
      id_q  <= '0;
    end else begin
      stb_q <= stb_d;
      off_q <= off_d;
      wr_q  <= wr_d;
      wd_q  <= wd_d;
      iak_q <= iak_d;
      ack_q <= ack_d;
      id_q  <= id_d;
    end
  end

  irq_level_unit #(
    .LVL_W (LVL_W),
    .ID_W  (ID_W),
    .DATA_W(DATA_W)
  ) i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_vec   (wr_vec),
    .wr_lvl   (wr_lvl),
    .wdata    (wd_q),
    .raise    (irq_raise),
    .iack_take(iak_q),
    .level    (level),
    .vector   (vector),
    .pending  (pending),
    .irq_req  (irq_req)
  );

  assign reg_stb   = stb_q;
  assign reg_off   = off_q;
  assign reg_wr    = wr_q;
  assign cyc_ack   = ack_q;
  assign status_id = id_q;

  p_stb_then_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb |=> cyc_ack);

  p_bad_am_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && !cyc_iack && !am_ok) |=> !reg_stb);

  p_iack_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && cyc_iack && !pending) |=> ##1 (status_id == '0));
endmodule

// File: tb/test_a16_window_slave.sv
module test_a16_window_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_fixed;
  logic [1:0]  strap_hi;
  logic [7:0]  strap_la;
  logic        cyc_req, cyc_iack, cyc_wr, irq_raise;
  logic [15:0] cyc_addr, cyc_wdata;
  logic [5:0]  cyc_am;
  logic [2:0]  iack_lvl;
  logic        reg_stb, reg_wr, cyc_ack;
  logic [4:0]  reg_off;
  logic [7:0]  status_id;
  logic [7:1]  irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  a16_window_slave i_a16_window_slave (
    .clk(clk), .rst_n(rst_n), .strap_fixed(strap_fixed), .strap_hi(strap_hi),
    .strap_la(strap_la), .cyc_req(cyc_req), .cyc_iack(cyc_iack),
    .cyc_addr(cyc_addr), .cyc_am(cyc_am), .cyc_wr(cyc_wr),
    .cyc_wdata(cyc_wdata), .iack_lvl(iack_lvl), .irq_raise(irq_raise),
    .reg_stb(reg_stb), .reg_off(reg_off), .reg_wr(reg_wr), .cyc_ack(cyc_ack),
    .status_id(status_id), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(input bit fx, input logic [1:0] hi,
                                 input logic [7:0] la, input logic [15:0] a,
                                 input logic [5:0] am);
    logic [1:0] top;
    top = fx ? 2'b11 : hi;
    return ((am == 6'h29) || (am == 6'h2D)) && (a[15:14] == top) && (a[13:6] == la);
  endfunction

  function automatic logic [15:0] hit_addr(input logic [4:0] woff);
    logic [1:0] top;
    top = strap_fixed ? 2'b11 : strap_hi;
    return {top, strap_la, woff, 1'b0};
  endfunction

  function automatic logic [6:0] line_of(input logic [2:0] lvl, input bit pend);
    return (pend && lvl != 0) ? 7'(1 << (lvl - 1)) : 7'd0;
  endfunction

  task automatic data_cycle(input logic [15:0] a, input logic [5:0] am, input bit wr,
                            input logic [15:0] wd, input string tag);
    bit h;
    h = exp_hit(strap_fixed, strap_hi, strap_la, a, am);
    cyc_req = 1; cyc_iack = 0; cyc_addr = a; cyc_am = am; cyc_wr = wr; cyc_wdata = wd;
    @(negedge clk);
    cyc_req = 0;
    chk(reg_stb == h, {tag, " stb"}, reg_stb, h);
    if (h) begin
      chk(reg_off == a[5:1], {tag, " off R4"}, reg_off, a[5:1]);
      chk(reg_wr == wr, {tag, " dir R4"}, reg_wr, wr);
    end
    @(negedge clk);
    chk(cyc_ack == h, {tag, " ack R4"}, cyc_ack, h);
  endtask

  task automatic iack_cycle(input logic [2:0] lvl, input bit exp_ack,
                            input logic [7:0] exp_id, input string tag);
    cyc_req = 1; cyc_iack = 1; iack_lvl = lvl; cyc_am = 6'h29;
    @(negedge clk);
    cyc_req = 0; cyc_iack = 0;
    chk(reg_stb == 0, {tag, " no stb"}, reg_stb, 0);
    @(negedge clk);
    chk(cyc_ack == exp_ack, {tag, " ack"}, cyc_ack, exp_ack);
    if (exp_ack) chk(status_id == exp_id, {tag, " id R9"}, status_id, exp_id);
  endtask

  task automatic pulse_raise();
    irq_raise = 1;
    @(negedge clk);
    irq_raise = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    rst_n = 0; strap_fixed = 1; strap_hi = 2'b01; strap_la = 8'h5A;
    cyc_req = 0; cyc_iack = 0; cyc_addr = 0; cyc_am = 6'h29; cyc_wr = 0;
    cyc_wdata = 0; iack_lvl = 0; irq_raise = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_stb == 0 && cyc_ack == 0, "R11 reset strobe/ack", {reg_stb, cyc_ack}, 0);
    chk(irq_req == 0 && status_id == 0, "R11 reset irq/id", irq_req, 0);

    // logical-address mode
    data_cycle(hit_addr(5'd3), 6'h29, 0, 16'h0, "R2 fixed hit");
    data_cycle({2'b10, 8'h5A, 6'h06}, 6'h2D, 1, 16'h0, "R2 fixed top miss");
    data_cycle({2'b11, 8'h5B, 6'h06}, 6'h2D, 0, 16'h0, "R2 fixed sw miss");
    data_cycle(hit_addr(5'd4), 6'h39, 0, 16'h0, "R1 bad am");
    data_cycle(hit_addr(5'd4), 6'h2D, 1, 16'h0, "R1 am 2D ok");

    // free-placement mode
    strap_fixed = 0;
    data_cycle({2'b01, 8'h5A, 6'h3E}, 6'h29, 1, 16'h0, "R3 free hit");
    data_cycle({2'b11, 8'h5A, 6'h3E}, 6'h29, 1, 16'h0, "R3 free top miss");

    // program vector and level
    data_cycle(hit_addr(5'h16), 6'h29, 1, 16'h77A5, "R5 vec write");
    data_cycle(hit_addr(5'h17), 6'h29, 1, 16'hFFF3, "R5 lvl write");
    chk(irq_req == 0, "R6 no line while idle", irq_req, 0);
    pulse_raise();
    chk(irq_req == line_of(3'd3, 1), "R6 R7 line 3 driven", irq_req, line_of(3'd3, 1));

    iack_cycle(3'd2, 0, 8'h00, "R8 wrong level");
    chk(irq_req == line_of(3'd3, 1), "R7 held after reject", irq_req, line_of(3'd3, 1));
    iack_cycle(3'd3, 1, 8'hA5, "R9 free vector");
    chk(irq_req == 0, "R10 released on ack", irq_req, 0);
    iack_cycle(3'd3, 0, 8'h00, "R8 not pending");

    // logical-address id
    strap_fixed = 1;
    pulse_raise();
    iack_cycle(3'd3, 1, 8'h5A, "R9 fixed la");
    chk(irq_req == 0, "R10 released fixed", irq_req, 0);

    // raise during ack edge wins
    pulse_raise();
    cyc_req = 1; cyc_iack = 1; iack_lvl = 3'd3;
    @(negedge clk);
    cyc_req = 0; cyc_iack = 0; irq_raise = 1;
    @(negedge clk);
    irq_raise = 0;
    chk(cyc_ack == 1, "R10 ack with raise", cyc_ack, 1);
    chk(irq_req == line_of(3'd3, 1), "R10 raise wins", irq_req, line_of(3'd3, 1));
    iack_cycle(3'd3, 1, 8'h5A, "R8 second ack");

    // level 0
    data_cycle(hit_addr(5'h17), 6'h29, 1, 16'h0000, "R5 lvl zero");
    pulse_raise();
    chk(irq_req == 0, "R6 level 0 quiet", irq_req, 0);
    iack_cycle(3'd0, 0, 8'h00, "R8 level 0 iack");
    data_cycle(hit_addr(5'h17), 6'h29, 1, 16'h0007, "R5 lvl seven");
    chk(irq_req == line_of(3'd7, 1), "R6 line 7", irq_req, line_of(3'd7, 1));
    iack_cycle(3'd7, 1, 8'h5A, "R9 level 7 ack");

    // random stream
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [5:0]  am;
      logic [4:0]  wo;
      bit          wr;
      strap_fixed = $urandom_range(0, 1);
      strap_hi = 2'($urandom);
      strap_la = 8'($urandom);
      wo = 5'($urandom_range(0, 21));
      a = hit_addr(wo);
      case ($urandom_range(0, 3))
        0: a[15:14] = 2'($urandom);
        1: a[6 + $urandom_range(0, 7)] ^= 1'b1;
        default: ;
      endcase
      am = ($urandom_range(0, 4) == 0) ? 6'($urandom) : (($urandom_range(0, 1) != 0) ? 6'h29 : 6'h2D);
      wr = $urandom_range(0, 1);
      data_cycle(a, am, wr, 16'($urandom), (strap_fixed ? "R2 random" : "R3 random"));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule